// File: doc/BRIEF.md
# Address Window Translator

This block rewrites addresses that cross a point-to-point link between a local bus and a remote peer. Requests leaving the chip carry an address taken from a 64 Mbyte local window: bits [25:0] of the bus address are kept, a programmable transmit base is subtracted, and the result is what the link carries. The outbound path is a single registered stage.

Packets arriving from the link carry addresses in the peer's view. In that view, four regions sit end to end starting at address 0: region 1 first, then 2, then 3, then 4. Each region has a size and an offset register. A small state machine walks the regions in order. In state `ST_IDLE` it accepts an address (`IDLE->SCAN`). In `ST_SCAN` it tests one region per cycle. If the remainder is below that region's size, it adds the region's offset (`SCAN->HIT`). If not, it subtracts the size and moves to the next region (`SCAN->SCAN`). After the fourth region fails it reports a miss (`SCAN->MISS`). `ST_HIT` and `ST_MISS` each present the result for one cycle and return to idle (`HIT->IDLE`, `MISS->IDLE`).

The map registers are loaded through a simple write port. Select code 0 is the transmit base. Codes 1, 3, 5 and 7 are the sizes of regions 1 to 4, and codes 2, 4, 6 and 8 are their offsets.

Top module: `addr_xlate_top`

## Requirements
- R1: After reset, all nine map registers are zero, `in_req_ready` is 1, and `out_rsp_valid` and `in_rsp_valid` are 0. With the registers still at zero, every inbound address misses.
- R2: A write with `cfg_sel` 0 to 8 loads the selected register with bits [1:0] forced to zero. The new value is used by the next translation accepted after the write edge. Writes with `cfg_sel` 9 to 15 change nothing.
- R3: One cycle after `out_req_valid`, `out_rsp_valid` is 1 and `out_rsp_addr` equals ({6'b0, `out_req_addr`[25:0]} minus transmit base) modulo 2^32. Address bits [31:26] are ignored.
- R4: An inbound address below the region 1 size translates to the address plus the region 1 offset, with `in_rsp_region` = 0.
- R5: Otherwise the sizes of earlier regions are subtracted in order 1 to 4. The first region whose size exceeds the remainder adds its offset, and `in_rsp_region` gives its index (0 to 3).
- R6: A region of size zero never matches and passes the remainder unchanged to the next region.
- R7: An address at or above the sum of the four sizes gives `in_rsp_miss` = 1 together with `in_rsp_valid`. The address and region outputs are then don't-care.
- R8: `in_req_ready` is 1 only in the idle state, so it drops the cycle after an accept. `in_rsp_valid` is a one-cycle pulse that arrives 2+k cycles after the accept edge for a hit in region k, and 5 cycles after it for a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_sel | input | 4 | Register select (0 base, 2k+1 size, 2k+2 offset) |
| cfg_wdata | input | 32 | Write data |
| out_req_valid | input | 1 | Outbound address valid |
| out_req_addr | input | 32 | Local bus address |
| out_rsp_valid | output | 1 | Outbound result valid |
| out_rsp_addr | output | 32 | Remote address |
| in_req_valid | input | 1 | Inbound address valid |
| in_req_ready | output | 1 | Walker idle, accepts an address |
| in_req_addr | input | 32 | Address from the link |
| in_rsp_valid | output | 1 | Inbound result pulse |
| in_rsp_miss | output | 1 | No region matched |
| in_rsp_region | output | 2 | Index of matching region |
| in_rsp_addr | output | 32 | Translated local address |

## Verification
Four things are checked by assertions on every cycle. The outbound result follows each request by one cycle. A base write lands word-aligned. The inbound result is a single-cycle pulse that never overlaps a new accept. A hit keeps the low two address bits of its request. Only the bench scenarios can show the arithmetic itself: that the cascade walks regions in order, that zero-size regions are skipped, that the boundaries fall exactly at the size sums, that the outbound subtraction wraps, and that writes to unused selects leave the translations unchanged.

// File: rtl/axl_pkg.sv
package axl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HIT,
        ST_MISS
    } walk_state_e;

    localparam int unsigned SEL_W     = 4;
    localparam logic [SEL_W-1:0] SEL_TXMAP = 4'd0;

    function automatic logic [SEL_W-1:0] sel_size(input int unsigned k);
        return SEL_W'(2 * k + 1);
    endfunction

    function automatic logic [SEL_W-1:0] sel_off(input int unsigned k);
        return SEL_W'(2 * k + 2);
    endfunction

endpackage

// File: rtl/axl_map_regs.sv
module axl_map_regs
    import axl_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned NREG = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [AW-1:0]             cfg_wdata,
    output logic [AW-1:0]             tx_map,
    output logic [NREG-1:0][AW-1:0]   reg_size,
    output logic [NREG-1:0][AW-1:0]   reg_off
);

    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_map <= '0;
        end else if (cfg_we && cfg_sel == SEL_TXMAP) begin
            tx_map <= cfg_wdata & ALIGN_MASK;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_region
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_size[g] <= '0;
                reg_off[g]  <= '0;
            end else if (cfg_we) begin
                if (cfg_sel == sel_size(g)) reg_size[g] <= cfg_wdata & ALIGN_MASK;
                if (cfg_sel == sel_off(g))  reg_off[g]  <= cfg_wdata & ALIGN_MASK;
            end
        end
    end

    AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_TXMAP) |=> (tx_map == ($past(cfg_wdata) & ALIGN_MASK))); // R2

endmodule

// File: rtl/axl_outbound.sv
module axl_outbound #(
    parameter int unsigned AW    = 32,
    parameter int unsigned WIN_W = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] tx_map,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr
);

    localparam int unsigned PAD = AW - WIN_W;

    logic [AW-1:0] window;
    assign window = {{PAD{1'b0}}, req_addr[WIN_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_addr <= window - tx_map;
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R3

endmodule

// File: rtl/axl_inbound_walker.sv
module axl_inbound_walker
    import axl_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned NREG = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG-1:0][AW-1:0]   reg_size,
    input  logic [NREG-1:0][AW-1:0]   reg_off,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [AW-1:0]             req_addr,
    output logic                      rsp_valid,
    output logic                      rsp_miss,
    output logic [$clog2(NREG)-1:0]   rsp_region,
    output logic [AW-1:0]             rsp_addr
);

    localparam int unsigned IDX_W = $clog2(NREG);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

    walk_state_e state_q, state_d;
    logic [AW-1:0]    rem_q;
    logic [AW-1:0]    res_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] region_q;
    logic [1:0]       lo_q;

    logic [AW-1:0] cur_size;
    logic [AW-1:0] cur_off;
    logic          fits;
    logic          last;

    always_comb begin
        cur_size = reg_size[idx_q];
        cur_off  = reg_off[idx_q];
        fits     = rem_q < cur_size;
        last     = idx_q == LAST_IDX;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_SCAN;
            ST_SCAN: begin
                if (fits)      state_d = ST_HIT;
                else if (last) state_d = ST_MISS;
            end
            ST_HIT:  state_d = ST_IDLE;
            ST_MISS: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            res_q    <= '0;
            idx_q    <= '0;
            region_q <= '0;
            lo_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                rem_q <= req_addr;
                idx_q <= '0;
                lo_q  <= req_addr[1:0];
            end else if (state_q == ST_SCAN) begin
                region_q <= idx_q;
                if (fits) begin
                    res_q <= rem_q + cur_off;
                end else begin
                    rem_q <= rem_q - cur_size;
                    if (!last) idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        req_ready  = state_q == ST_IDLE;
        rsp_valid  = state_q == ST_HIT || state_q == ST_MISS;
        rsp_miss   = state_q == ST_MISS;
        rsp_addr   = res_q;
        rsp_region = region_q;
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_MISS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> rsp_valid); // R7
    AST_HIT_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss) |-> (rsp_addr[1:0] == lo_q)); // R4

endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top
    import axl_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned WIN_W = 26,
    parameter int unsigned NREG  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [3:0]              cfg_sel,
    input  logic [AW-1:0]           cfg_wdata,
    input  logic                    out_req_valid,
    input  logic [AW-1:0]           out_req_addr,
    output logic                    out_rsp_valid,
    output logic [AW-1:0]           out_rsp_addr,
    input  logic                    in_req_valid,
    output logic                    in_req_ready,
    input  logic [AW-1:0]           in_req_addr,
    output logic                    in_rsp_valid,
    output logic                    in_rsp_miss,
    output logic [$clog2(NREG)-1:0] in_rsp_region,
    output logic [AW-1:0]           in_rsp_addr
);

    logic [AW-1:0]           tx_map;
    logic [NREG-1:0][AW-1:0] reg_size;
    logic [NREG-1:0][AW-1:0] reg_off;

    axl_map_regs #(.AW(AW), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tx_map(tx_map), .reg_size(reg_size), .reg_off(reg_off)
    );

    axl_outbound #(.AW(AW), .WIN_W(WIN_W)) u_out (
        .clk(clk), .rst_n(rst_n), .req_valid(out_req_valid), .req_addr(out_req_addr),
        .tx_map(tx_map), .rsp_valid(out_rsp_valid), .rsp_addr(out_rsp_addr)
    );

    axl_inbound_walker #(.AW(AW), .NREG(NREG)) u_in (
        .clk(clk), .rst_n(rst_n), .reg_size(reg_size), .reg_off(reg_off),
        .req_valid(in_req_valid), .req_ready(in_req_ready), .req_addr(in_req_addr),
        .rsp_valid(in_rsp_valid), .rsp_miss(in_rsp_miss), .rsp_region(in_rsp_region),
        .rsp_addr(in_rsp_addr)
    );

endmodule

// File: tb/tb_addr_xlate_top.sv
module tb_addr_xlate_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        out_req_valid = 1'b0;
    logic [31:0] out_req_addr = '0;
    logic        out_rsp_valid;
    logic [31:0] out_rsp_addr;
    logic        in_req_valid = 1'b0;
    logic        in_req_ready;
    logic [31:0] in_req_addr = '0;
    logic        in_rsp_valid;
    logic        in_rsp_miss;
    logic [1:0]  in_rsp_region;
    logic [31:0] in_rsp_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    addr_xlate_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .out_req_valid(out_req_valid), .out_req_addr(out_req_addr),
        .out_rsp_valid(out_rsp_valid), .out_rsp_addr(out_rsp_addr),
        .in_req_valid(in_req_valid), .in_req_ready(in_req_ready), .in_req_addr(in_req_addr),
        .in_rsp_valid(in_rsp_valid), .in_rsp_miss(in_rsp_miss),
        .in_rsp_region(in_rsp_region), .in_rsp_addr(in_rsp_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] m_tx = '0;
    logic [31:0] m_size [4] = '{default: '0};
    logic [31:0] m_off  [4] = '{default: '0};

    logic [31:0] oq_addr [$];
    string       oq_tag  [$];
    logic [31:0] iq_addr [$];
    logic        iq_miss [$];
    logic [1:0]  iq_reg  [$];
    string       iq_tag  [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        if (sel == 4'd0) m_tx = data & ~32'd3;
        else if (sel <= 4'd8) begin
            if (sel[0]) m_size[(sel - 1) / 2] = data & ~32'd3;
            else        m_off[(sel - 2) / 2]  = data & ~32'd3;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_out(input logic [31:0] a, input string tag);
        @(negedge clk);
        out_req_valid = 1'b1; out_req_addr = a;
        oq_addr.push_back({6'b0, a[25:0]} - m_tx);
        oq_tag.push_back(tag);
        @(negedge clk);
        out_req_valid = 1'b0;
    endtask

    task automatic drive_in(input logic [31:0] a, input string tag);
        logic [31:0] rem;
        logic        hit;
        @(negedge clk);
        while (!in_req_ready) @(negedge clk);
        in_req_valid = 1'b1; in_req_addr = a;
        rem = a; hit = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (!hit) begin
                if (rem < m_size[k]) begin
                    hit = 1'b1;
                    iq_addr.push_back(rem + m_off[k]);
                    iq_reg.push_back(2'(k));
                end else begin
                    rem = rem - m_size[k];
                end
            end
        end
        if (!hit) begin
            iq_addr.push_back('0);
            iq_reg.push_back('0);
        end
        iq_miss.push_back(!hit);
        iq_tag.push_back(tag);
        @(negedge clk);
        in_req_valid = 1'b0;
        check("R8 ready after accept", {31'b0, in_req_ready}, 32'd0);
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_rsp_valid) begin
                if (oq_addr.size() == 0) check("R3 unexpected outbound", 32'd1, 32'd0);
                else check(oq_tag.pop_front(), out_rsp_addr, oq_addr.pop_front());
            end
            if (in_rsp_valid) begin
                if (iq_addr.size() == 0) check("R8 unexpected inbound", 32'd1, 32'd0);
                else begin
                    automatic string       t = iq_tag.pop_front();
                    automatic logic        em = iq_miss.pop_front();
                    automatic logic [31:0] ea = iq_addr.pop_front();
                    automatic logic [1:0]  er = iq_reg.pop_front();
                    check({t, " miss"}, {31'b0, in_rsp_miss}, {31'b0, em});
                    if (!em) begin
                        check({t, " addr"}, in_rsp_addr, ea);
                        check({t, " region"}, {30'b0, in_rsp_region}, {30'b0, er});
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", {31'b0, in_req_ready}, 32'd1);
        check("R1 out valid", {31'b0, out_rsp_valid}, 32'd0);
        check("R1 in valid", {31'b0, in_rsp_valid}, 32'd0);

        drive_out(32'hFFFF_FFFF, "R1 R3 zero base, top bits dropped");
        drive_in(32'h0000_0000, "R1 R7 all sizes zero");

        cfg_write(4'd0, 32'h0000_0003);
        drive_out(32'h0000_0054, "R2 base low bits forced");
        cfg_write(4'd0, 32'h0010_0000);
        drive_out(32'hFC10_0154, "R3 subtract base");
        drive_out(32'h0000_0010, "R3 wrap below base");

        cfg_write(4'd1, 32'h0000_0103);
        cfg_write(4'd2, 32'h8000_0000);
        cfg_write(4'd5, 32'h0000_0200);
        cfg_write(4'd6, 32'h9000_0000);
        cfg_write(4'd7, 32'h0000_1000);
        cfg_write(4'd8, 32'hA000_0000);

        drive_in(32'h0000_0054, "R4 region one");
        drive_in(32'h0000_00FF, "R2 R4 size low bits forced");
        drive_in(32'h0000_0100, "R5 R6 skip empty region");
        drive_in(32'h0000_02FF, "R5 region three top");
        drive_in(32'h0000_0300, "R5 region four base");
        drive_in(32'h0000_12FF, "R5 region four top");
        drive_in(32'h0000_1300, "R7 beyond all sizes");
        drive_in(32'hFFFF_FFF0, "R7 far beyond");

        cfg_write(4'd15, 32'hFFFF_FFFF);
        cfg_write(4'd9, 32'hFFFF_FFFF);
        drive_in(32'h0000_0054, "R2 unused select ignored");
        drive_out(32'h0010_0154, "R2 unused select keeps base");

        cfg_write(4'd3, 32'h0000_0040);
        cfg_write(4'd4, 32'h7000_0000);
        drive_in(32'h0000_0100, "R2 R5 new region two");
        drive_in(32'h0000_0140, "R5 region three after region two");

        repeat (10) @(negedge clk);
        check("R8 inbound queue drained", iq_addr.size(), 32'd0);
        check("R3 outbound queue drained", oq_addr.size(), 32'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule